// File: doc/BRIEF.md
# Bus Clock Ratio Strobe Generator

This block derives three clock-enable strobes from a single fast source clock that comes from the first PLL. The strobes serve the processor domain, the system bus domain and the peripheral bus domain. Logic in each domain runs on the source clock and advances only in cycles where its strobe is high. The block therefore sets the effective frequency of each domain without creating any new clock.

The ratios come from three select fields in a 32-bit clock-set word. The processor and system bus selects each index their own eight-entry divisor table. The system bus table includes the non-power-of-two ratios 5 and 6. The peripheral select does not divide the source clock. It divides the system bus strobe, so the peripheral ratio is always applied on top of the bus ratio.

When the select fields change, the new ratios are held back until the current system bus period ends. At that point all counters restart together, so every domain keeps a clean phase relation to the others.

Top module: `clk_ratio_gen`

## Requirements
- R1: While `rst` is high all three strobes are low. In the first cycle after `rst` falls, all three strobes are high together.
- R2: The processor select is `cfg_word[27:25]`. Codes 0..7 give divisors 1, 2, 4, 8, 16, 1, 1, 1. `cpu_en` is a one-cycle pulse once every divisor cycles.
- R3: The system bus select is `cfg_word[22:20]`. Codes 0..7 give divisors 1, 2, 4, 5, 6, 8, 16, 32. `bus_en` is a one-cycle pulse once every divisor cycles.
- R4: The peripheral select is `cfg_word[19:18]`. Codes 0..3 give divisors 1, 2, 4, 8, counted in system bus strobes. `per_en` therefore pulses once every (bus divisor × peripheral divisor) source cycles.
- R5: A strobe whose total divisor is 1 stays high in every cycle.
- R6: `per_en` is high only in cycles where `bus_en` is also high.
- R7: When the select fields differ from the active ratios, the old ratios run on until the last cycle of the current bus period. The following cycle has all three strobes high, and the new ratios apply from that cycle on.
- R8: Bits of `cfg_word` outside the three select fields have no effect on the strobes. Changing them causes no restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock taken from the first PLL |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Clock-set word holding the three select fields |
| cpu_en | output | 1 | Processor domain clock-enable strobe |
| bus_en | output | 1 | System bus domain clock-enable strobe |
| per_en | output | 1 | Peripheral bus domain clock-enable strobe |

## Verification
The assertions assume `cfg_word` changes only on clock edges, from a register in the same domain, and never takes X once reset has been applied. They also assume `rst` is held for at least one edge before any strobe is used. The stimulus drives `cfg_word` and `rst` one time unit after each rising edge and holds `rst` for several edges before every run. It changes the select fields mid-period to exercise the deferred restart, and toggles only non-field bits to show that those bits are ignored.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;

    localparam int CFG_W      = 32;
    localparam int CPU_LSB    = 25;
    localparam int BUS_LSB    = 20;
    localparam int PER_LSB    = 18;
    localparam int CPU_SEL_W  = 3;
    localparam int BUS_SEL_W  = 3;
    localparam int PER_SEL_W  = 2;
    localparam int MAX_DIV    = 32;
    localparam int PER_MAX    = 8;
    localparam int CNT_W      = $clog2(MAX_DIV);
    localparam int PCNT_W     = $clog2(PER_MAX);

    typedef struct packed {
        logic [CPU_SEL_W-1:0] cpu;
        logic [BUS_SEL_W-1:0] bus;
        logic [PER_SEL_W-1:0] per;
    } ratio_sel_t;

    typedef struct packed {
        logic [CNT_W-1:0]  cpu;
        logic [CNT_W-1:0]  bus;
        logic [PCNT_W-1:0] per;
    } ratio_last_t;

    // terminal count (divisor minus one) for the processor table
    function automatic logic [CNT_W-1:0] cpu_last(input logic [CPU_SEL_W-1:0] s);
        case (s)
            3'd1:    return CNT_W'(1);
            3'd2:    return CNT_W'(3);
            3'd3:    return CNT_W'(7);
            3'd4:    return CNT_W'(15);
            default: return CNT_W'(0);
        endcase
    endfunction

    // terminal count for the system bus table, with ratios 5 and 6
    function automatic logic [CNT_W-1:0] bus_last(input logic [BUS_SEL_W-1:0] s);
        case (s)
            3'd0:    return CNT_W'(0);
            3'd1:    return CNT_W'(1);
            3'd2:    return CNT_W'(3);
            3'd3:    return CNT_W'(4);
            3'd4:    return CNT_W'(5);
            3'd5:    return CNT_W'(7);
            3'd6:    return CNT_W'(15);
            default: return CNT_W'(31);
        endcase
    endfunction

    // peripheral ratio counted in bus strobes: 1, 2, 4, 8
    function automatic logic [PCNT_W-1:0] per_last(input logic [PER_SEL_W-1:0] s);
        return PCNT_W'((1 << s) - 1);
    endfunction

    function automatic ratio_sel_t pick_fields(input logic [CFG_W-1:0] w);
        ratio_sel_t r;
        r.cpu = w[CPU_LSB +: CPU_SEL_W];
        r.bus = w[BUS_LSB +: BUS_SEL_W];
        r.per = w[PER_LSB +: PER_SEL_W];
        return r;
    endfunction

endpackage

// File: rtl/ratio_decode.sv
module ratio_decode
    import clk_ratio_pkg::*;
(
    input  ratio_sel_t  sel,
    output ratio_last_t last
);
    always_comb begin
        last.cpu = cpu_last(sel.cpu);
        last.bus = bus_last(sel.bus);
        last.per = per_last(sel.per);
    end
endmodule

// File: rtl/strobe_counter.sv
module strobe_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         adv,
    input  logic [W-1:0] last,
    output logic         at_zero,
    output logic         at_last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= (cnt_q == last) ? '0 : cnt_q + W'(1);
        end
    end

    assign at_zero = (cnt_q == '0);
    assign at_last = (cnt_q == last);

    // the count never passes the terminal value of the active ratio
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last);

endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
    import clk_ratio_pkg::*;
#(
    parameter int CW = CFG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cfg_word,
    output logic          cpu_en,
    output logic          bus_en,
    output logic          per_en
);
    ratio_sel_t  req_sel;
    ratio_sel_t  act_q;
    ratio_last_t lim;
    logic        pending;
    logic        restart;
    logic        cpu_zero, cpu_end;
    logic        bus_zero, bus_end;
    logic        per_zero, per_end;
    logic        rst_q;

    assign req_sel = pick_fields(CFG_W'(cfg_word));
    assign pending = (req_sel != act_q);
    assign restart = pending && bus_end;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            act_q <= req_sel;
        end
    end

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    ratio_decode u_dec (
        .sel  (act_q),
        .last (lim)
    );

    strobe_counter #(.W(CNT_W)) u_cpu (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .adv     (1'b1),
        .last    (lim.cpu),
        .at_zero (cpu_zero),
        .at_last (cpu_end)
    );

    strobe_counter #(.W(CNT_W)) u_bus (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .adv     (1'b1),
        .last    (lim.bus),
        .at_zero (bus_zero),
        .at_last (bus_end)
    );

    strobe_counter #(.W(PCNT_W)) u_per (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .adv     (bus_zero),
        .last    (lim.per),
        .at_zero (per_zero),
        .at_last (per_end)
    );

    assign cpu_en = !rst && cpu_zero;
    assign bus_en = !rst && bus_zero;
    assign per_en = !rst && bus_zero && per_zero;

    assert_quiet_in_reset_R1: assert property (@(posedge clk)
        rst |-> !(cpu_en || bus_en || per_en));

    assert_aligned_start_R1: assert property (@(posedge clk)
        (!rst && rst_q) |-> (cpu_en && bus_en && per_en));

    assert_cpu_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_en && !cpu_end && !restart) |=> !cpu_en);

    assert_bus_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_end && !restart) |=> !bus_en);

    assert_per_step_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !per_end && !restart) |=> !per_en);

    assert_bus_held_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_zero && bus_end) |=> bus_en);

    assert_per_subset_R6: assert property (@(posedge clk) disable iff (rst)
        per_en |-> bus_en);

    assert_restart_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cpu_en && bus_en && per_en));

    assert_no_spurious_reload_R8: assert property (@(posedge clk) disable iff (rst)
        !pending |=> $stable(act_q));

endmodule

// File: tb/sim_clk_ratio_gen.sv
module sim_clk_ratio_gen;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = '0;
    logic        cpu_en, bus_en, per_en;

    typedef struct {
        logic  rst_exp;
        logic  cpu;
        logic  bus;
        logic  per;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    int        m_cd, m_bd, m_pd, m_t;
    logic [7:0] m_sel;

    always #(PERIOD/2) clk = ~clk;

    clk_ratio_gen u0 (
        .clk      (clk),
        .rst      (rst),
        .cfg_word (cfg_word),
        .cpu_en   (cpu_en),
        .bus_en   (bus_en),
        .per_en   (per_en)
    );

    function automatic logic [31:0] mk(input int c, input int b, input int p, input logic [31:0] other);
        logic [31:0] w;
        w = other & ~32'h0E7C_0000;
        w[27:25] = c[2:0];
        w[22:20] = b[2:0];
        w[19:18] = p[1:0];
        return w;
    endfunction

    function automatic logic [7:0] fields(input logic [31:0] w);
        return {w[27:25], w[22:20], w[19:18]};
    endfunction

    function automatic int cpu_div(input logic [2:0] s);
        case (s)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd4: return 16;
            default: return 1;
        endcase
    endfunction

    function automatic int bus_div(input logic [2:0] s);
        case (s)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 5;
            3'd4: return 6;
            3'd5: return 8;
            3'd6: return 16;
            default: return 32;
        endcase
    endfunction

    function automatic int per_div(input logic [1:0] s);
        return 1 << s;
    endfunction

    task automatic load_model(input logic [31:0] w);
        m_sel = fields(w);
        m_cd  = cpu_div(w[27:25]);
        m_bd  = bus_div(w[22:20]);
        m_pd  = per_div(w[19:18]);
        m_t   = 0;
    endtask

    task automatic do_reset(input logic [31:0] w);
        exp_t e;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            rst = 1'b1;
            cfg_word = w;
            e.rst_exp = 1'b1; e.cpu = 1'b0; e.bus = 1'b0; e.per = 1'b0; e.tag = "R1";
            q.push_back(e);
        end
        load_model(w);
    endtask

    task automatic step(input logic [31:0] w, input string tag);
        exp_t e;
        @(posedge clk); #1;
        rst = 1'b0;
        cfg_word = w;
        e.rst_exp = 1'b0;
        e.cpu = (m_t % m_cd) == 0;
        e.bus = (m_t % m_bd) == 0;
        e.per = (m_t % (m_bd * m_pd)) == 0;
        e.tag = (m_t == 0) ? {tag, "/R1-R7 aligned start"} : tag;
        q.push_back(e);
        if (fields(w) != m_sel && (m_t % m_bd) == m_bd - 1) load_model(w);
        else m_t++;
    endtask

    task automatic run(input logic [31:0] w, input int n, input string tag);
        for (int i = 0; i < n; i++) step(w, tag);
    endtask

    // monitor: pops one expected item per cycle, samples at the falling edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if ({cpu_en, bus_en, per_en} !== {e.cpu, e.bus, e.per}) begin
                errors++;
                $display("FAIL %s t=%0t cpu/bus/per actual=%b%b%b expected=%b%b%b",
                         e.tag, $time, cpu_en, bus_en, per_en, e.cpu, e.bus, e.per);
            end
            checks++;
            if (per_en && !bus_en) begin
                errors++;
                $display("FAIL R6 t=%0t per_en=%b bus_en=%b expected per_en only with bus_en",
                         $time, per_en, bus_en);
            end
        end
    end

    initial begin
        // R1 + R5: all divisors 1, every strobe high every cycle
        do_reset(mk(0, 0, 0, 32'h0));
        run(mk(0, 0, 0, 32'h0), 20, "R5");
        // R5: processor code 6 also maps to 1
        do_reset(mk(6, 0, 0, 32'h0));
        run(mk(6, 0, 0, 32'h0), 10, "R5");
        // R3 ratio 5 with R4 peripheral /2 and R2 processor /4
        do_reset(mk(2, 3, 1, 32'h0));
        run(mk(2, 3, 1, 32'h0), 60, "R3");
        // R3 ratio 6, R4 peripheral /8, R2 processor /16
        do_reset(mk(4, 4, 3, 32'h0));
        run(mk(4, 4, 3, 32'h0), 150, "R4");
        // R2 processor /8, R3 bus /32, R4 /4
        do_reset(mk(3, 7, 2, 32'h0));
        run(mk(3, 7, 2, 32'h0), 300, "R2");
        // R3 bus /16 and /8, peripheral /1
        do_reset(mk(1, 6, 0, 32'h0));
        run(mk(1, 6, 0, 32'h0), 40, "R3");
        do_reset(mk(5, 5, 0, 32'h0));
        run(mk(5, 5, 0, 32'h0), 40, "R3");
        // R7: change fields mid bus period, restart deferred to boundary
        do_reset(mk(2, 3, 1, 32'h0));
        run(mk(2, 3, 1, 32'h0), 7, "R7");
        run(mk(1, 1, 0, 32'h0), 30, "R7");
        run(mk(4, 4, 2, 32'h0), 60, "R7");
        run(mk(0, 2, 1, 32'h0), 3, "R7");
        run(mk(3, 0, 0, 32'h0), 20, "R7");
        // R8: only non-field bits toggle, no restart expected
        do_reset(mk(2, 3, 1, 32'h0));
        run(mk(2, 3, 1, 32'h0), 3, "R8");
        run(mk(2, 3, 1, 32'hF1C3_FFFF), 4, "R8");
        run(mk(2, 3, 1, 32'h0003_5A5A), 5, "R8");
        run(mk(2, 3, 1, 32'h8000_0001), 40, "R8");
        @(posedge clk); #1;
        @(posedge clk); #1;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule